// File: doc/BRIEF.md
# Stack Frame Sequencer

This block owns the processor's 16-bit stack pointer and moves context bytes between the core and a byte-wide memory. A small command interface asks for one of four sequences: save the interrupt context, restore it, save a subroutine return address, or restore that address. For saves, the command carries the program counter and the accumulator, index-low and condition-code bytes. For restores, the recovered values come back on dedicated outputs together with a one-cycle completion strobe. The interrupt frame is five bytes long and never includes the upper index byte. A subroutine frame is two bytes long.

The command interface is a valid/ready stream. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low for the whole time a sequence runs. A requester that keeps `cmd_valid` high must also keep its command fields steady until the transfer happens. The memory port moves one byte per clock and reads combinationally: `mem_rdata` must reflect `mem_addr` within the same cycle. The pointer can also be loaded directly while the sequencer is idle. An error flag marks every memory access that falls outside the RAM window `0x0040`..`0x043F`.

Top module: `stack_frame_seq`

## Requirements
- R1: After reset the pointer reads 0x00FF, `cmd_ready` is high, and `mem_en` and `done` are low.
- R2: Opcode 0 (interrupt entry) writes five bytes at sp, sp-1, sp-2, sp-3 and sp-4, in the order PC[7:0], PC[15:8], X, A, CCR. It writes no sixth byte, so the upper index byte is never stored, and the pointer ends 5 lower.
- R3: Opcode 1 (interrupt return) reads sp+1..sp+5 into CCR, A, X, PC[15:8] and PC[7:0] in that order, and the pointer ends 5 higher.
- R4: Opcode 2 (call) writes PC[7:0] at sp and PC[15:8] at sp-1, and the pointer ends 2 lower.
- R5: Opcode 3 (return) reads PC[15:8] from sp+1 and PC[7:0] from sp+2, and the pointer ends 2 higher.
- R6: A write goes to the current pointer and then decrements it. A read first increments the pointer and then reads the new address. All pointer arithmetic wraps modulo 65536.
- R7: Bytes move one per cycle, starting in the cycle after the command transfers. `cmd_ready` is low and `mem_en` is high for exactly the frame length.
- R8: `done` is high for one cycle, in the cycle right after the last byte. In that cycle `ret_pc`, `ret_a`, `ret_x` and `ret_ccr` hold the restored values.
- R9: When `sp_load` is high, no sequence is running and no command transfers, the pointer equals `sp_load_val` in the next cycle.
- R10: A load asserted while a sequence runs, or in the same cycle a command transfers, is ignored. The pointer changes only through loads and memory accesses.
- R11: `stk_err` is high exactly in the cycles where `mem_en` is high and `mem_addr` lies outside 0x0040..0x043F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command can transfer |
| cmd_op | input | 2 | 0 irq entry, 1 irq return, 2 call, 3 return |
| cmd_pc | input | 16 | Program counter to save |
| cmd_a | input | 8 | Accumulator to save |
| cmd_x | input | 8 | Index low byte to save |
| cmd_ccr | input | 8 | Condition codes to save |
| done | output | 1 | Sequence finished strobe |
| ret_pc | output | 16 | Restored program counter |
| ret_a | output | 8 | Restored accumulator |
| ret_x | output | 8 | Restored index low byte |
| ret_ccr | output | 8 | Restored condition codes |
| sp_load | input | 1 | Direct pointer load request |
| sp_load_val | input | 16 | Value for direct load |
| sp | output | 16 | Current stack pointer |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, same cycle as address |
| stk_err | output | 1 | Access outside stack RAM |

## Verification
The bench builds the block with its default parameters: a reset pointer of 0x00FF and a RAM window of 0x0040..0x043F. Direct pointer loads put the frames right at the lower window edge, so a single interrupt frame straddles 0x0040 and its error flags turn on in the middle of the frame. A load to 0x0000 drives a call and a return across the 16-bit wrap. A command held valid while a sequence runs exercises back-pressure and a transfer in the done cycle.

// File: rtl/stkseq_pkg.sv
`timescale 1ns/1ps
package stkseq_pkg;
  typedef enum logic [1:0] {
    OP_IRQ  = 2'd0,
    OP_RTI  = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } stk_op_e;

  localparam int unsigned IRQ_BYTES = 5;
  localparam int unsigned SUB_BYTES = 2;
  localparam int unsigned CNT_W     = $clog2(IRQ_BYTES);

  // frame slot positions (slot 0 is written first)
  localparam int unsigned SLOT_PCL = 0;
  localparam int unsigned SLOT_PCH = 1;
  localparam int unsigned SLOT_X   = 2;
  localparam int unsigned SLOT_A   = 3;
  localparam int unsigned SLOT_CCR = 4;

  function automatic logic op_is_push(input stk_op_e op);
    return (op == OP_IRQ) || (op == OP_CALL);
  endfunction

  function automatic logic op_is_irq(input stk_op_e op);
    return (op == OP_IRQ) || (op == OP_RTI);
  endfunction
endpackage

// File: rtl/stkseq_ptr.sv
`timescale 1ns/1ps
module stkseq_ptr #(
  parameter int unsigned    AW     = 16,
  parameter logic [AW-1:0] SP_RST = 16'h00FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_dn,
  input  logic          step_up,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] sp
);
  always_ff @(posedge clk) begin
    if (!rst_n)       sp <= SP_RST;
    else if (step_dn) sp <= sp - AW'(1);
    else if (step_up) sp <= sp + AW'(1);
    else if (load)    sp <= load_val;
  end
endmodule

// File: rtl/stkseq_ctrl.sv
`timescale 1ns/1ps
module stkseq_ctrl
  import stkseq_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  stk_op_e       cmd_op,
  output logic          cmd_ready,
  output logic          accept,
  output logic          busy,
  output logic          push,
  output logic [CW-1:0] idx,
  output logic          done
);
  stk_op_e       op_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] len_m1;
  logic          last;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign push      = op_is_push(op_q);
  assign len_m1    = op_is_irq(op_q) ? CW'(IRQ_BYTES - 1) : CW'(SUB_BYTES - 1);
  assign last      = busy && (cnt == len_m1);
  // pushes walk slots upward, pulls walk them downward
  assign idx       = push ? cnt : (len_m1 - cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      op_q <= OP_IRQ;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        busy <= 1'b1;
        op_q <= cmd_op;
        cnt  <= '0;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        else      cnt  <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/stkseq_frame.sv
`timescale 1ns/1ps
module stkseq_frame #(
  parameter int unsigned DW    = 8,
  parameter int unsigned SLOTS = 5,
  parameter int unsigned IW    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SLOTS*DW-1:0] load_vec,
  input  logic                wr_en,
  input  logic [IW-1:0]       idx,
  input  logic [DW-1:0]       wr_data,
  output logic [DW-1:0]       rd_byte,
  output logic [SLOTS*DW-1:0] slots_vec
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                           q <= '0;
      else if (load)                        q <= load_vec[s*DW +: DW];
      else if (wr_en && (idx == IW'(s)))    q <= wr_data;
    end
    assign slots_vec[s*DW +: DW] = q;
  end

  always_comb begin
    rd_byte = '0;
    for (int s = 0; s < SLOTS; s++)
      if (idx == IW'(s)) rd_byte = slots_vec[s*DW +: DW];
  end
endmodule

// File: rtl/stkseq_range.sv
`timescale 1ns/1ps
module stkseq_range #(
  parameter int unsigned    AW = 16,
  parameter logic [AW-1:0] LO = 16'h0040,
  parameter logic [AW-1:0] HI = 16'h043F
) (
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic          err
);
  assign err = en && ((addr < LO) || (addr > HI));
endmodule

// File: rtl/stack_frame_seq.sv
`timescale 1ns/1ps
module stack_frame_seq
  import stkseq_pkg::*;
#(
  parameter int unsigned    AW     = 16,
  parameter int unsigned    DW     = 8,
  parameter logic [AW-1:0] SP_RST = 16'h00FF,
  parameter logic [AW-1:0] RAM_LO = 16'h0040,
  parameter logic [AW-1:0] RAM_HI = 16'h043F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_pc,
  input  logic [DW-1:0] cmd_a,
  input  logic [DW-1:0] cmd_x,
  input  logic [DW-1:0] cmd_ccr,
  output logic          done,
  output logic [AW-1:0] ret_pc,
  output logic [DW-1:0] ret_a,
  output logic [DW-1:0] ret_x,
  output logic [DW-1:0] ret_ccr,
  input  logic          sp_load,
  input  logic [AW-1:0] sp_load_val,
  output logic [AW-1:0] sp,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          stk_err
);
  localparam int unsigned SLOTS = IRQ_BYTES;
  localparam int unsigned FW    = SLOTS * DW;

  logic             accept, busy, push;
  logic [CNT_W-1:0] idx;
  logic [FW-1:0]    slots_vec, load_vec;

  stkseq_ctrl #(.CW(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(stk_op_e'(cmd_op)),
    .cmd_ready(cmd_ready), .accept(accept), .busy(busy), .push(push),
    .idx(idx), .done(done)
  );

  stkseq_ptr #(.AW(AW), .SP_RST(SP_RST)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .step_dn(busy && push), .step_up(busy && !push),
    .load(sp_load && !busy && !cmd_valid), .load_val(sp_load_val),
    .sp(sp)
  );

  assign load_vec = {cmd_ccr, cmd_a, cmd_x, cmd_pc[AW-1:DW], cmd_pc[DW-1:0]};

  stkseq_frame #(.DW(DW), .SLOTS(SLOTS), .IW(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_vec(load_vec),
    .wr_en(busy && !push), .idx(idx), .wr_data(mem_rdata),
    .rd_byte(mem_wdata), .slots_vec(slots_vec)
  );

  assign mem_en   = busy;
  assign mem_we   = busy && push;
  assign mem_addr = push ? sp : (sp + AW'(1));

  assign ret_pc  = {slots_vec[SLOT_PCH*DW +: DW], slots_vec[SLOT_PCL*DW +: DW]};
  assign ret_x   = slots_vec[SLOT_X*DW +: DW];
  assign ret_a   = slots_vec[SLOT_A*DW +: DW];
  assign ret_ccr = slots_vec[SLOT_CCR*DW +: DW];

  stkseq_range #(.AW(AW), .LO(RAM_LO), .HI(RAM_HI)) u_range (
    .en(mem_en), .addr(mem_addr), .err(stk_err)
  );
endmodule

// File: rtl/stkseq_chk.sv
`timescale 1ns/1ps
module stkseq_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          sp_load,
  input logic [AW-1:0] sp_load_val,
  input logic [AW-1:0] sp,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic          stk_err
);
  // R7
  busy_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !cmd_ready);
  // R6
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (mem_addr == sp));
  // R6
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |=> (sp == $past(sp) - AW'(1)));
  // R6
  pull_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> (mem_addr == sp + AW'(1)));
  // R6
  pull_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> (sp == $past(mem_addr)));
  // R8
  done_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_en && $past(mem_en)));
  // R9
  load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_load && cmd_ready && !cmd_valid) |=> (sp == $past(sp_load_val)));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_en && !(sp_load && cmd_ready && !cmd_valid)) |=> $stable(sp));
  // R11
  err_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |-> mem_en);
endmodule

bind stack_frame_seq stkseq_chk #(.AW(AW)) u_stkseq_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .sp_load(sp_load), .sp_load_val(sp_load_val), .sp(sp), .mem_en(mem_en),
  .mem_we(mem_we), .mem_addr(mem_addr), .done(done), .stk_err(stk_err)
);

// File: tb/test_stack_frame_seq.sv
`timescale 1ns/1ps
module test_stack_frame_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_ready, done, sp_load = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [15:0] cmd_pc = '0, ret_pc, sp_load_val = '0, sp, mem_addr;
  logic [7:0]  cmd_a = '0, cmd_x = '0, cmd_ccr = '0, ret_a, ret_x, ret_ccr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_en, mem_we, stk_err;

  stack_frame_seq i_stack_frame_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_pc(cmd_pc), .cmd_a(cmd_a), .cmd_x(cmd_x), .cmd_ccr(cmd_ccr),
    .done(done), .ret_pc(ret_pc), .ret_a(ret_a), .ret_x(ret_x), .ret_ccr(ret_ccr),
    .sp_load(sp_load), .sp_load_val(sp_load_val), .sp(sp), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .stk_err(stk_err)
  );

  // byte memory, aliased on the low 11 address bits
  logic [7:0] ram [0:2047];
  assign mem_rdata = ram[mem_addr[10:0]];
  always @(posedge clk) if (mem_en && mem_we) ram[mem_addr[10:0]] <= mem_wdata;

  int total = 0, failed = 0, cyc = 0, err_cycles = 0;
  bit started = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct { bit we; logic [15:0] addr; logic [7:0] data; } acc_t;
  acc_t       q[$];
  logic [15:0] m_sp;
  bit          m_done;
  logic [7:0]  m_f [5];

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      m_sp = 16'h00FF; q.delete(); m_done = 0;
    end else if (q.size() != 0) begin
      acc_t a;
      a = q.pop_front();
      m_sp = a.we ? m_sp - 16'd1 : m_sp + 16'd1;
      m_done = (q.size() == 0);
    end else begin
      m_done = 0;
      if (cmd_valid) begin
        int len;
        bit pu;
        len = (cmd_op == 2'd0 || cmd_op == 2'd1) ? 5 : 2;
        pu  = (cmd_op == 2'd0 || cmd_op == 2'd2);
        m_f[0] = cmd_pc[7:0]; m_f[1] = cmd_pc[15:8];
        m_f[2] = cmd_x; m_f[3] = cmd_a; m_f[4] = cmd_ccr;
        for (int k = 0; k < len; k++) begin
          if (pu) q.push_back('{1'b1, m_sp - 16'(k), m_f[k]});
          else begin
            logic [15:0] ad;
            ad = m_sp + 16'd1 + 16'(k);
            m_f[len-1-k] = ram[ad[10:0]];
            q.push_back('{1'b0, ad, 8'h00});
          end
        end
      end else if (sp_load) m_sp = sp_load_val;
    end
  end

  always @(negedge clk) if (started) begin
    if (stk_err) err_cycles++;
    chk("R7 cmd_ready", 32'(cmd_ready), 32'(q.size() == 0));
    chk("R6/R9/R10 sp", 32'(sp), 32'(m_sp));
    chk("R7 mem_en", 32'(mem_en), 32'(q.size() != 0));
    chk("R8 done", 32'(done), 32'(m_done));
    if (q.size() != 0) begin
      chk("R6 direction", 32'(mem_we), 32'(q[0].we));
      chk("R2/R3/R4/R5 addr", 32'(mem_addr), 32'(q[0].addr));
      if (q[0].we) chk("R2/R4 data", 32'(mem_wdata), 32'(q[0].data));
      chk("R11 err", 32'(stk_err),
          32'(q[0].addr < 16'h0040 || q[0].addr > 16'h043F));
    end else chk("R11 err idle", 32'(stk_err), 32'd0);
    if (m_done) begin
      chk("R8 ret_pc", 32'(ret_pc), 32'({m_f[1], m_f[0]}));
      chk("R8 ret_x", 32'(ret_x), 32'(m_f[2]));
      chk("R8 ret_a", 32'(ret_a), 32'(m_f[3]));
      chk("R8 ret_ccr", 32'(ret_ccr), 32'(m_f[4]));
    end
  end

  // ---------------- stimulus ----------------
  task automatic put_cmd(input logic [1:0] op, input logic [15:0] pc,
                         input logic [7:0] a, input logic [7:0] x, input logic [7:0] c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pc = pc; cmd_a = a; cmd_x = x; cmd_ccr = c;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1 cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic load_sp(input logic [15:0] v);
    @(negedge clk); sp_load = 1'b1; sp_load_val = v;
    @(posedge clk); #1 sp_load = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failed++; total++;
      $display("FAIL watchdog: actual %0d expected <20000", cyc);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    int e0;
    for (int i = 0; i < 2048; i++) ram[i] = 8'(i) ^ 8'h5A;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sp", 32'(sp), 32'h00FF);
    chk("R1 ready", 32'(cmd_ready), 32'd1);
    chk("R1 mem_en/done", 32'({mem_en, done}), 32'd0);

    // interrupt entry from reset pointer
    put_cmd(2'd0, 16'hBEEF, 8'h11, 8'h22, 8'h33);
    wait_done();
    chk("R2 sp", 32'(sp), 32'h00FA);
    chk("R2 pcl", 32'(ram[11'h0FF]), 32'hEF);
    chk("R2 ccr", 32'(ram[11'h0FB]), 32'h33);
    chk("R2 no sixth byte", 32'(ram[11'h0FA]), 32'(8'hFA ^ 8'h5A));

    // interrupt return
    put_cmd(2'd1, 16'h0000, 8'h00, 8'h00, 8'h00);
    wait_done();
    chk("R3 pc", 32'(ret_pc), 32'hBEEF);
    chk("R3 a/x/ccr", 32'({ret_a, ret_x, ret_ccr}), 32'h112233);
    chk("R3 sp", 32'(sp), 32'h00FF);

    // call, then a return held valid while busy (back-pressure)
    put_cmd(2'd2, 16'h1234, 8'h00, 8'h00, 8'h00);
    @(negedge clk); sp_load = 1'b1; sp_load_val = 16'h0300;
    @(posedge clk); #1 sp_load = 1'b0;
    put_cmd(2'd3, 16'h0000, 8'h00, 8'h00, 8'h00);
    wait_done();
    chk("R4/R5 ret pc", 32'(ret_pc), 32'h1234);
    chk("R10 load refused", 32'(sp), 32'h00FF);

    // load together with a command: refused
    @(negedge clk);
    sp_load = 1'b1; sp_load_val = 16'h0200;
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_pc = 16'h5566;
    @(posedge clk); #1 sp_load = 1'b0; cmd_valid = 1'b0;
    wait_done();
    chk("R10 load with cmd", 32'(sp), 32'h00FD);

    // direct load to the lower RAM edge, frame straddles it
    load_sp(16'h0041);
    @(negedge clk);
    chk("R9 load", 32'(sp), 32'h0041);
    e0 = err_cycles;
    put_cmd(2'd0, 16'hCAFE, 8'hA1, 8'hB2, 8'hC3);
    wait_done();
    chk("R11 err count", 32'(err_cycles - e0), 32'd3);
    put_cmd(2'd1, 16'h0000, 8'h00, 8'h00, 8'h00);
    wait_done();
    chk("R3 edge restore", 32'({ret_pc, ret_a, ret_x, ret_ccr}), 32'(64'hCAFEA1B2C3));

    // wrap across 0x0000
    load_sp(16'h0000);
    put_cmd(2'd2, 16'h7788, 8'h00, 8'h00, 8'h00);
    wait_done();
    chk("R6 wrap sp", 32'(sp), 32'hFFFE);
    put_cmd(2'd3, 16'h0000, 8'h00, 8'h00, 8'h00);
    wait_done();
    chk("R5/R6 wrap pc", 32'(ret_pc), 32'h7788);
    chk("R6 wrap back", 32'(sp), 32'h0000);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule